// File: doc/BRIEF.md
# Watchdog and Stop-Mode Controller

This block supervises a small controller core in two ways. A free-running watchdog counter advances once per instruction cycle. Unless software clears it in time, it issues a one-instruction-cycle reset pulse to the core. The clear comes from a dedicated clear strobe, or optionally from activity on the remote output port. The block also sequences the low-power stop mode.

A stop request gates the oscillator and halts the core. A falling level on any wake input that the configuration enables restarts the oscillator. Execution then resumes only after a fixed settling count of oscillator clocks. If an enabled wake input is already low when the request arrives, the request does nothing. The watchdog is held at zero for as long as the core is not running, so it always restarts from zero after a wake-up.

An external reset pin is qualified by a consecutive-clock filter. Short glitches are ignored. A held level resets the core and returns the sequencer to its running state.

Top module: `wdt_stop_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, `cpu_rst` is 0, `osc_en` is 1, `run_en` is 1 and `stop_act` is 0.
- R2: With no clear, the watchdog fires on the WDT_LIMIT-th `cyc_tick` counted from zero. `cpu_rst` then goes to 1 one clock after that tick edge and stays 1 until the next tick edge. The counter restarts from zero at the same time.
- R3: A `wdt_clr` strobe returns the count to zero. A clear given together with a tick suppresses firing on that tick, and WDT_LIMIT further ticks are then needed to fire.
- R4: When REM_CLR_EN is 1, a `rem_evt` strobe clears the watchdog exactly like `wdt_clr`.
- R5: A `stop_req` strobe in the running state, with no enabled wake input low after synchronization, sets `stop_act`=1, `osc_en`=0 and `run_en`=0 from the next clock.
- R6: If an enabled wake input is already low (synchronized) when `stop_req` arrives, the request is ignored and the outputs stay in the running state.
- R7: In stop mode, an enabled `wake_n` bit going low passes two synchronizer flops. On the third clock edge after the change, `osc_en` becomes 1 and `stop_act` becomes 0. `run_en` stays 0 for SETTLE_CLKS clocks and rises on the edge at which the settle count ends.
- R8: A `wake_n` bit whose bit of WAKE_EN is 0 has no effect in stop mode.
- R9: The watchdog is held at zero and cannot fire while stopped or settling. After resuming, a full WDT_LIMIT ticks are needed to fire, whatever the count was before stop.
- R10: `rst_pin_n` held low for PIN_MIN_CLKS consecutive clocks drives `cpu_rst` to 1 on the PIN_MIN_CLKS-th edge. A shorter low pulse has no effect. The qualified pin reset also clears the watchdog and returns the sequencer to the running state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator-rate clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| rst_pin_n | input | 1 | External reset pin, active low, filtered here |
| cyc_tick | input | 1 | One-clock pulse per instruction cycle |
| wdt_clr | input | 1 | Watchdog clear strobe from the clear instruction |
| rem_evt | input | 1 | Remote-port output event strobe |
| stop_req | input | 1 | Stop instruction strobe |
| wake_n | input | WAKE_W | Active-low wake inputs (key and I/O lines) |
| cpu_rst | output | 1 | Reset to the core (watchdog pulse or qualified pin reset) |
| osc_en | output | 1 | Oscillator enable |
| run_en | output | 1 | Core run enable |
| stop_act | output | 1 | High while stop mode is active |

## Verification
The bench builds the block with WDT_LIMIT=32, SETTLE_CLKS=16, PIN_MIN_CLKS=24, WAKE_EN=8'hA5 and REM_CLR_EN=1. The short watchdog period makes many overflows, and clears placed just before an overflow, fit into a few thousand clocks. With the short settle count, the exact rising edge of `run_en` can be checked clock by clock. The mixed wake mask lets the same run show an enabled line waking the block, a masked line being ignored, and an enabled line cancelling a stop request.

// File: rtl/wdt_stop_pkg.sv
package wdt_stop_pkg;

    typedef enum logic [1:0] {
        PS_RUN    = 2'd0,
        PS_STOP   = 2'd1,
        PS_SETTLE = 2'd2
    } pwr_state_e;

    typedef struct packed {
        logic osc_en;
        logic run_en;
        logic stop_act;
    } pwr_ctl_t;

    function automatic pwr_ctl_t ctl_of(pwr_state_e s);
        pwr_ctl_t c;
        case (s)
            PS_STOP:   c = '{osc_en: 1'b0, run_en: 1'b0, stop_act: 1'b1};
            PS_SETTLE: c = '{osc_en: 1'b1, run_en: 1'b0, stop_act: 1'b0};
            default:   c = '{osc_en: 1'b1, run_en: 1'b1, stop_act: 1'b0};
        endcase
        return c;
    endfunction

    function automatic int cnt_bits(int limit);
        return (limit < 2) ? 1 : $clog2(limit);
    endfunction

endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
    parameter int                WIDTH  = 8,
    parameter logic [WIDTH-1:0]  ENABLE = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] wake_n,
    output logic             wake
);
    logic [WIDTH-1:0] s1_n, s2_n;
    logic [WIDTH-1:0] hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_n <= '1;
            s2_n <= '1;
        end else begin
            s1_n <= wake_n;
            s2_n <= s1_n;
        end
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (ENABLE[i]) begin : g_on
            assign hit[i] = ~s2_n[i];
        end else begin : g_off
            assign hit[i] = 1'b0;
        end
    end

    assign wake = |hit;

    // R8: a line that stays high through both stages cannot raise wake
    a_r8_quiet_lines: assert property (@(posedge clk) disable iff (rst)
        (&wake_n && &s1_n && &s2_n) |=> !wake);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_stop_pkg::*;
#(
    parameter int LIMIT = 8192
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic clr,
    input  logic hold,
    output logic fire
);
    localparam int CW = cnt_bits(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            cnt  <= '0;
            fire <= 1'b0;
        end else if (clr) begin
            cnt <= '0;
            if (tick) fire <= 1'b0;
        end else if (tick) begin
            if (cnt == LAST) begin
                cnt  <= '0;
                fire <= 1'b1;
            end else begin
                cnt  <= cnt + 1'b1;
                fire <= 1'b0;
            end
        end
    end

    // R2: the pulse lasts until the next instruction tick
    a_r2_pulse_holds: assert property (@(posedge clk) disable iff (rst)
        (fire && !tick && !hold) |=> fire);
    // R3: clearing on a tick never fires
    a_r3_clear_no_fire: assert property (@(posedge clk) disable iff (rst)
        (clr && tick) |=> !fire);
    // R9: no watchdog reset while the core is halted
    a_r9_hold_quiet: assert property (@(posedge clk) disable iff (rst)
        hold |=> !fire);
endmodule

// File: rtl/stop_seq.sv
module stop_seq
    import wdt_stop_pkg::*;
#(
    parameter int SETTLE_CLKS = 8192
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     stop_req,
    input  logic     wake,
    output pwr_ctl_t ctl
);
    localparam int SW = cnt_bits(SETTLE_CLKS);
    localparam logic [SW-1:0] SLAST = SW'(SETTLE_CLKS - 1);

    pwr_state_e    state;
    logic [SW-1:0] settle_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= PS_RUN;
            settle_cnt <= '0;
        end else begin
            case (state)
                PS_RUN: begin
                    settle_cnt <= '0;
                    if (stop_req && !wake) state <= PS_STOP;
                end
                PS_STOP: begin
                    settle_cnt <= '0;
                    if (wake) state <= PS_SETTLE;
                end
                PS_SETTLE: begin
                    if (settle_cnt == SLAST) begin
                        state      <= PS_RUN;
                        settle_cnt <= '0;
                    end else begin
                        settle_cnt <= settle_cnt + 1'b1;
                    end
                end
                default: state <= PS_RUN;
            endcase
        end
    end

    assign ctl = ctl_of(state);

    // R5: a clean stop request halts the core
    a_r5_enter_stop: assert property (@(posedge clk) disable iff (rst)
        (state == PS_RUN && stop_req && !wake) |=> state == PS_STOP);
    // R6: a pending wake cancels the request
    a_r6_stop_noop: assert property (@(posedge clk) disable iff (rst)
        (state == PS_RUN && stop_req && wake) |=> state == PS_RUN);
    // R7: a wake in stop starts the settling phase
    a_r7_wake_settle: assert property (@(posedge clk) disable iff (rst)
        (state == PS_STOP && wake) |=> state == PS_SETTLE);
endmodule

// File: rtl/rst_qual.sv
module rst_qual
    import wdt_stop_pkg::*;
#(
    parameter int MIN_CLKS = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic pin_rst
);
    localparam int QW = cnt_bits(MIN_CLKS);
    localparam logic [QW-1:0] QLAST = QW'(MIN_CLKS - 1);

    logic [QW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst || pin_n) begin
            low_cnt <= '0;
            pin_rst <= 1'b0;
        end else if (low_cnt == QLAST) begin
            pin_rst <= 1'b1;
        end else begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    // R10: a released pin ends the reset on the next edge
    a_r10_release: assert property (@(posedge clk) disable iff (rst)
        pin_n |=> !pin_rst);
endmodule

// File: rtl/wdt_stop_ctrl.sv
module wdt_stop_ctrl
    import wdt_stop_pkg::*;
#(
    parameter int                WDT_LIMIT    = 8192,
    parameter int                SETTLE_CLKS  = 8192,
    parameter int                PIN_MIN_CLKS = 24,
    parameter int                WAKE_W       = 8,
    parameter logic [WAKE_W-1:0] WAKE_EN      = '1,
    parameter bit                REM_CLR_EN   = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rst_pin_n,
    input  logic              cyc_tick,
    input  logic              wdt_clr,
    input  logic              rem_evt,
    input  logic              stop_req,
    input  logic [WAKE_W-1:0] wake_n,
    output logic              cpu_rst,
    output logic              osc_en,
    output logic              run_en,
    output logic              stop_act
);
    logic     pin_rst, core_rst, wake, wdt_fire, clr_any;
    pwr_ctl_t ctl;

    assign core_rst = rst | pin_rst;
    assign clr_any  = wdt_clr | (REM_CLR_EN & rem_evt);

    rst_qual #(.MIN_CLKS(PIN_MIN_CLKS)) u_qual (
        .clk(clk), .rst(rst), .pin_n(rst_pin_n), .pin_rst(pin_rst)
    );

    wake_sync #(.WIDTH(WAKE_W), .ENABLE(WAKE_EN)) u_wake (
        .clk(clk), .rst(core_rst), .wake_n(wake_n), .wake(wake)
    );

    stop_seq #(.SETTLE_CLKS(SETTLE_CLKS)) u_seq (
        .clk(clk), .rst(core_rst), .stop_req(stop_req), .wake(wake), .ctl(ctl)
    );

    wdt_counter #(.LIMIT(WDT_LIMIT)) u_wdt (
        .clk(clk), .rst(core_rst), .tick(cyc_tick), .clr(clr_any),
        .hold(!ctl.run_en), .fire(wdt_fire)
    );

    assign cpu_rst  = wdt_fire | pin_rst;
    assign osc_en   = ctl.osc_en;
    assign run_en   = ctl.run_en;
    assign stop_act = ctl.stop_act;

    // R7: the core never runs without its oscillator
    a_r7_run_needs_osc: assert property (@(posedge clk) disable iff (rst)
        run_en |-> osc_en);
    // R5: stop gates the oscillator
    a_r5_stop_gates_osc: assert property (@(posedge clk) disable iff (rst)
        stop_act |-> (!osc_en && !run_en));
endmodule

// File: tb/wdt_stop_ctrl_test.sv
module wdt_stop_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int LIM        = 32;
    localparam int SETTLE     = 16;
    localparam int PMIN       = 24;
    localparam logic [7:0] WEN = 8'hA5;

    logic       clk = 1'b0;
    logic       rst, rst_pin_n, cyc_tick, wdt_clr, rem_evt, stop_req;
    logic [7:0] wake_n;
    logic       cpu_rst, osc_en, run_en, stop_act;

    int n_run = 0;
    int n_fail = 0;
    int m_cnt = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_stop_ctrl #(
        .WDT_LIMIT(LIM), .SETTLE_CLKS(SETTLE), .PIN_MIN_CLKS(PMIN),
        .WAKE_W(8), .WAKE_EN(WEN), .REM_CLR_EN(1'b1)
    ) uut (
        .clk(clk), .rst(rst), .rst_pin_n(rst_pin_n), .cyc_tick(cyc_tick),
        .wdt_clr(wdt_clr), .rem_evt(rem_evt), .stop_req(stop_req),
        .wake_n(wake_n), .cpu_rst(cpu_rst), .osc_en(osc_en),
        .run_en(run_en), .stop_act(stop_act)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // model of the watchdog for one tick; returns expected pulse
    function automatic bit wdt_step(bit clr);
        bit f;
        if (clr) begin
            m_cnt = 0;
            f = 1'b0;
        end else if (m_cnt == LIM - 1) begin
            m_cnt = 0;
            f = 1'b1;
        end else begin
            m_cnt++;
            f = 1'b0;
        end
        return f;
    endfunction

    // one instruction cycle = 6 clocks; tick in the first
    task automatic tick_chk(bit clr, bit rem, string req);
        bit e;
        e = wdt_step(clr | rem);
        cyc_tick = 1'b1; wdt_clr = clr; rem_evt = rem;
        @(negedge clk);
        cyc_tick = 1'b0; wdt_clr = 1'b0; rem_evt = 1'b0;
        chk(req, {31'd0, cpu_rst}, {31'd0, e});
        repeat (5) @(negedge clk);
        chk(req, {31'd0, cpu_rst}, {31'd0, e});
    endtask

    task automatic tick_plain();
        cyc_tick = 1'b1;
        @(negedge clk);
        cyc_tick = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic chk_ctl(string req, bit o, bit r, bit s);
        chk(req, {29'd0, osc_en, run_en, stop_act}, {29'd0, o, r, s});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1; rst_pin_n = 1'b1; cyc_tick = 1'b0; wdt_clr = 1'b0;
        rem_evt = 1'b0; stop_req = 1'b0; wake_n = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", {31'd0, cpu_rst}, 32'd0);
        chk_ctl("R1", 1'b1, 1'b1, 1'b0);

        // R2 overflow after LIM ticks and pulse on the following tick ends
        m_cnt = 0;
        for (int i = 0; i < LIM + 1; i++) tick_chk(1'b0, 1'b0, "R2");

        // R3 clear just before overflow
        for (int i = 0; i < LIM - 2; i++) tick_chk(1'b0, 1'b0, "R3");
        tick_chk(1'b1, 1'b0, "R3");
        for (int i = 0; i < LIM; i++) tick_chk(1'b0, 1'b0, "R3");

        // R4 remote event clears
        for (int i = 0; i < LIM - 3; i++) tick_chk(1'b0, 1'b0, "R4");
        tick_chk(1'b0, 1'b1, "R4");
        for (int i = 0; i < LIM; i++) tick_chk(1'b0, 1'b0, "R4");

        // random mix of clears
        for (int i = 0; i < 300; i++) begin
            int r;
            r = int'($urandom_range(0, 59));
            tick_chk(r == 0, r == 1, (r == 1) ? "R4" : "R3");
        end

        // R6 pending enabled wake (bit 2) makes stop a no-op
        wake_n = 8'hFB;
        repeat (3) @(negedge clk);
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        chk_ctl("R6", 1'b1, 1'b1, 1'b0);
        repeat (3) @(negedge clk);
        chk_ctl("R6", 1'b1, 1'b1, 1'b0);
        wake_n = 8'hFF;
        repeat (3) @(negedge clk);

        // advance watchdog part way, then stop
        for (int i = 0; i < 10; i++) tick_chk(1'b0, 1'b0, "R9");
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        chk_ctl("R5", 1'b0, 1'b0, 1'b1);
        // R9 ticks while stopped cannot fire
        for (int i = 0; i < LIM + 4; i++) begin
            tick_plain();
            if (i % 12 == 0) chk("R9", {31'd0, cpu_rst}, 32'd0);
        end
        // R8 masked line (bit 1) does not wake
        wake_n = 8'hFD;
        repeat (6) @(negedge clk);
        chk_ctl("R8", 1'b0, 1'b0, 1'b1);
        // R7 enabled line (bit 0) wakes after two sync stages
        wake_n = 8'hFC;
        repeat (2) @(negedge clk);
        chk_ctl("R7", 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        chk_ctl("R7", 1'b1, 1'b0, 1'b0);
        wake_n = 8'hFF;
        repeat (SETTLE - 1) @(negedge clk);
        chk_ctl("R7", 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        chk_ctl("R7", 1'b1, 1'b1, 1'b0);

        // R9 full period needed after resume
        m_cnt = 0;
        for (int i = 0; i < LIM + 1; i++) tick_chk(1'b0, 1'b0, "R9");

        // R10 short pin pulse ignored
        rst_pin_n = 1'b0;
        repeat (PMIN - 1) @(negedge clk);
        chk("R10", {31'd0, cpu_rst}, 32'd0);
        rst_pin_n = 1'b1;
        @(negedge clk);
        chk("R10", {31'd0, cpu_rst}, 32'd0);

        // R10 qualified pin reset from stop mode
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        chk_ctl("R5", 1'b0, 1'b0, 1'b1);
        rst_pin_n = 1'b0;
        repeat (PMIN - 1) @(negedge clk);
        chk("R10", {31'd0, cpu_rst}, 32'd0);
        @(negedge clk);
        chk("R10", {31'd0, cpu_rst}, 32'd1);
        @(negedge clk);
        chk_ctl("R10", 1'b1, 1'b1, 1'b0);
        rst_pin_n = 1'b1;
        @(negedge clk);
        chk("R10", {31'd0, cpu_rst}, 32'd0);
        chk_ctl("R10", 1'b1, 1'b1, 1'b0);
        m_cnt = 0;
        for (int i = 0; i < LIM + 1; i++) tick_chk(1'b0, 1'b0, "R10");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule